// File: doc/BRIEF.md
# Sized Load/Store Bus Adapter

This block sits between a processor core and a 32-bit classic Wishbone bus. The core hands it one load or store at a time. Each request carries a byte address, a two-bit access size, a write flag and write data held in the low bits of the core word. The adapter turns the request into a single classic bus cycle. It works out which byte lanes to select, shifts the store data onto those lanes, and holds cycle and strobe until the target acknowledges.

The lane order is big-endian: byte offset 0 is the most significant lane (bits 31:24) and offset 3 is the least significant (bits 7:0). A halfword at an odd offset is not treated as a fault. It rounds down to the aligned lane pair that contains it. On a load, the adapter decodes the active select pattern, moves the chosen byte or halfword down to bit 0, and clears the unused upper bits. The core sees a busy flag while the cycle runs and a one-cycle done pulse that carries the load data.

Top module: `sized_bus_adapter`

## Requirements
- R1: With size code 00 (byte), the select lines are 1000, 0100, 0010 and 0001 for byte offsets 0, 1, 2 and 3. Bit 3 of the select is the lane at bits 31:24.
- R2: With size code 01 (halfword), offsets 0 and 1 select 1100, and offsets 2 and 3 select 0011.
- R3: Size code 10 (word) selects all four lanes. Size code 11 selects no lane and places a zero data word on the bus.
- R4: Store data is taken from the low bits of the core word and copied onto every selected lane. A byte goes to its lane. A halfword goes to bits 31:16 or 15:0, with its upper byte in the higher lane. A word goes out unchanged. Lanes that are not selected carry zero.
- R5: Load data comes from the select pattern: the selected byte or halfword is returned in the low bits with the upper bits zero, and a full select returns the whole word. Any other pattern, including no select, returns zero.
- R6: The cycle type output is always 000 (classic) and the burst type output is always 00.
- R7: A request accepted while idle raises bus cycle and strobe on the next clock. Address, select, write enable and write data appear in that same clock. All of them stay stable until acknowledge is sampled.
- R8: On the clock edge that samples acknowledge, cycle and strobe drop. The done output then goes high for exactly one clock, and the load data output is valid while it is high.
- R9: Busy is high for the whole bus cycle. A request presented while busy is ignored: it neither changes the running cycle nor starts a later one.
- R10: Synchronous active-high reset returns the block to idle with cycle, strobe, select, done and busy all low, and it also aborts a cycle in progress.
- R11: The bus word address equals bits ADDR_W-1 down to 2 of the core byte address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_req | input | 1 | Request valid from the core |
| core_we | input | 1 | 1 = store, 0 = load |
| core_size | input | 2 | Access size code (00 byte, 01 halfword, 10 word) |
| core_addr | input | ADDR_W | Byte address |
| core_wdata | input | 32 | Store data, right-justified |
| core_busy | output | 1 | Bus cycle in progress |
| core_done | output | 1 | One-cycle completion pulse |
| core_rdata | output | 32 | Right-justified load data |
| bus_cyc | output | 1 | Bus cycle |
| bus_stb | output | 1 | Bus strobe |
| bus_we | output | 1 | Bus write enable |
| bus_adr | output | ADDR_W-2 | Bus word address |
| bus_sel | output | 4 | Byte lane selects |
| bus_wdat | output | 32 | Bus write data |
| bus_cti | output | 3 | Cycle type tag |
| bus_bte | output | 2 | Burst type tag |
| bus_rdat | input | 32 | Bus read data |
| bus_ack | input | 1 | Bus acknowledge |

## Verification
Two events can fall in the same clock: the completion of one transfer and the acceptance of the next. When acknowledge is sampled, done rises while the core is no longer busy, so a request held high in that cycle is launched on the following edge. The bench keeps the request asserted with new parameters through the done cycle. It then checks that done returns the first transfer's load data while the bus already carries the second transfer's select and address one clock later, with no idle gap lost or extra cycle inserted.

// File: rtl/sba_pkg.sv
package sba_pkg;

    localparam int SBA_DATA_W = 32;
    localparam int SBA_LANE_W = 8;
    localparam int SBA_LANES  = SBA_DATA_W / SBA_LANE_W;
    localparam int SBA_OFF_W  = $clog2(SBA_LANES);
    localparam int SBA_HALF_W = 2 * SBA_LANE_W;

    typedef logic [SBA_LANES-1:0]  lane_mask_t;
    typedef logic [SBA_DATA_W-1:0] word_t;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_NONE = 2'b11
    } acc_size_e;

    typedef enum logic {
        ST_IDLE,
        ST_ACTIVE
    } xfer_state_e;

    // Lane-side request payload held for the length of one bus cycle
    typedef struct packed {
        logic       we;
        lane_mask_t sel;
        word_t      wdat;
    } lane_req_t;

    localparam logic [2:0] CTI_CLASSIC = 3'b000;
    localparam logic [1:0] BTE_LINEAR  = 2'b00;

    // Does lane 'lane' (0 = least significant) take part in the access?
    // Lane position counted from the most significant end equals the byte offset.
    function automatic logic lane_hit(acc_size_e sz, logic [SBA_OFF_W-1:0] off, int lane);
        int pos;
        pos = SBA_LANES - 1 - lane;
        case (sz)
            SZ_BYTE: return (pos == int'(off));
            SZ_HALF: return ((pos >> 1) == (int'(off) >> 1));
            SZ_WORD: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    // Right-justify the lanes named by a legal select pattern; anything else gives zero
    function automatic word_t unpack_read(lane_mask_t sel, word_t din);
        word_t r;
        int    n;
        r = '0;
        n = $countones(sel);
        if (sel == {SBA_LANES{1'b1}}) begin
            r = din;
        end else if (n == 1) begin
            for (int l = 0; l < SBA_LANES; l++) begin
                if (sel[l]) r[SBA_LANE_W-1:0] = din[l*SBA_LANE_W +: SBA_LANE_W];
            end
        end else if (n == 2) begin
            for (int k = 0; k < SBA_LANES/2; k++) begin
                if (sel == (lane_mask_t'(2'b11) << (2*k)))
                    r[SBA_HALF_W-1:0] = din[k*SBA_HALF_W +: SBA_HALF_W];
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/sba_lane_encoder.sv
module sba_lane_encoder
    import sba_pkg::*;
(
    input  acc_size_e              size,
    input  logic [SBA_OFF_W-1:0]   offset,
    input  word_t                  wdata,
    output lane_mask_t             sel,
    output word_t                  wdat
);

    for (genvar g = 0; g < SBA_LANES; g++) begin : g_lane
        logic                  hit;
        logic [SBA_LANE_W-1:0] src;

        assign hit = lane_hit(size, offset, g);

        always_comb begin
            case (size)
                SZ_BYTE: src = wdata[SBA_LANE_W-1:0];
                SZ_HALF: src = wdata[(g % 2)*SBA_LANE_W +: SBA_LANE_W];
                SZ_WORD: src = wdata[g*SBA_LANE_W +: SBA_LANE_W];
                default: src = '0;
            endcase
        end

        assign sel[g]                           = hit;
        assign wdat[g*SBA_LANE_W +: SBA_LANE_W] = hit ? src : '0;
    end

endmodule

// File: rtl/sba_lane_decoder.sv
module sba_lane_decoder
    import sba_pkg::*;
(
    input  lane_mask_t sel,
    input  word_t      bus_data,
    output word_t      core_data
);

    assign core_data = unpack_read(sel, bus_data);

endmodule

// File: rtl/sba_xfer_ctrl.sv
module sba_xfer_ctrl
    import sba_pkg::*;
#(
    parameter int ADR_W = 30
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic [ADR_W-1:0] adr_in,
    input  lane_req_t        lane_in,
    input  logic             ack,
    input  word_t            rdata_dec,
    output logic             active,
    output logic [ADR_W-1:0] adr_q,
    output lane_req_t        lane_q,
    output logic             done,
    output word_t            rdata
);

    xfer_state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            adr_q  <= '0;
            lane_q <= '0;
            done   <= 1'b0;
            rdata  <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req) begin
                        state  <= ST_ACTIVE;
                        adr_q  <= adr_in;
                        lane_q <= lane_in;
                    end
                end
                ST_ACTIVE: begin
                    if (ack) begin
                        state  <= ST_IDLE;
                        adr_q  <= '0;
                        lane_q <= '0;
                        done   <= 1'b1;
                        rdata  <= rdata_dec;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign active = (state == ST_ACTIVE);

endmodule

// File: rtl/sized_bus_adapter.sv
module sized_bus_adapter
    import sba_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              core_req,
    input  logic              core_we,
    input  logic [1:0]        core_size,
    input  logic [ADDR_W-1:0] core_addr,
    input  logic [31:0]       core_wdata,
    output logic              core_busy,
    output logic              core_done,
    output logic [31:0]       core_rdata,
    output logic              bus_cyc,
    output logic              bus_stb,
    output logic              bus_we,
    output logic [ADDR_W-3:0] bus_adr,
    output logic [3:0]        bus_sel,
    output logic [31:0]       bus_wdat,
    output logic [2:0]        bus_cti,
    output logic [1:0]        bus_bte,
    input  logic [31:0]       bus_rdat,
    input  logic              bus_ack
);

    localparam int WADR_W = ADDR_W - SBA_OFF_W;

    lane_mask_t enc_sel;
    word_t      enc_wdat;
    word_t      dec_rdata;
    lane_req_t  lane_in;
    lane_req_t  lane_q;
    logic       active;

    sba_lane_encoder u_enc (
        .size   (acc_size_e'(core_size)),
        .offset (core_addr[SBA_OFF_W-1:0]),
        .wdata  (core_wdata),
        .sel    (enc_sel),
        .wdat   (enc_wdat)
    );

    assign lane_in = '{we: core_we, sel: enc_sel, wdat: enc_wdat};

    sba_xfer_ctrl #(.ADR_W(WADR_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req       (core_req),
        .adr_in    (core_addr[ADDR_W-1:SBA_OFF_W]),
        .lane_in   (lane_in),
        .ack       (bus_ack),
        .rdata_dec (dec_rdata),
        .active    (active),
        .adr_q     (bus_adr),
        .lane_q    (lane_q),
        .done      (core_done),
        .rdata     (core_rdata)
    );

    sba_lane_decoder u_dec (
        .sel       (lane_q.sel),
        .bus_data  (bus_rdat),
        .core_data (dec_rdata)
    );

    assign bus_cyc   = active;
    assign bus_stb   = active;
    assign core_busy = active;
    assign bus_we    = lane_q.we;
    assign bus_sel   = lane_q.sel;
    assign bus_wdat  = lane_q.wdat;
    assign bus_cti   = CTI_CLASSIC;
    assign bus_bte   = BTE_LINEAR;

endmodule

// File: rtl/sba_checker.sv
module sba_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              core_req,
    input logic              core_busy,
    input logic              core_done,
    input logic              bus_cyc,
    input logic              bus_stb,
    input logic              bus_we,
    input logic [ADDR_W-3:0] bus_adr,
    input logic [3:0]        bus_sel,
    input logic [31:0]       bus_wdat,
    input logic              bus_ack
);

    // R7
    launch_chk: assert property (@(posedge clk) disable iff (rst)
        core_req && !core_busy |=> bus_cyc && bus_stb);

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        bus_cyc && !bus_ack |=> bus_cyc && $stable(bus_sel) && $stable(bus_adr)
                                && $stable(bus_wdat) && $stable(bus_we));

    // R8
    ack_release_chk: assert property (@(posedge clk) disable iff (rst)
        bus_cyc && bus_ack |=> !bus_cyc && !bus_stb && core_done);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        core_done |=> !core_done);

    // R1
    sel_shape_chk: assert property (@(posedge clk) disable iff (rst)
        bus_cyc |-> $countones(bus_sel) != 3);

    // R10
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> !bus_cyc && !core_done && !core_busy);

endmodule

bind sized_bus_adapter sba_checker #(.ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .core_req  (core_req),
    .core_busy (core_busy),
    .core_done (core_done),
    .bus_cyc   (bus_cyc),
    .bus_stb   (bus_stb),
    .bus_we    (bus_we),
    .bus_adr   (bus_adr),
    .bus_sel   (bus_sel),
    .bus_wdat  (bus_wdat),
    .bus_ack   (bus_ack)
);

// File: tb/sized_bus_adapter_tb_top.sv
`timescale 1ns/1ps
module sized_bus_adapter_tb_top;

    localparam int ADDR_W = 32;

    logic              clk = 1'b0;
    logic              rst;
    logic              core_req;
    logic              core_we;
    logic [1:0]        core_size;
    logic [ADDR_W-1:0] core_addr;
    logic [31:0]       core_wdata;
    logic              core_busy;
    logic              core_done;
    logic [31:0]       core_rdata;
    logic              bus_cyc;
    logic              bus_stb;
    logic              bus_we;
    logic [ADDR_W-3:0] bus_adr;
    logic [3:0]        bus_sel;
    logic [31:0]       bus_wdat;
    logic [2:0]        bus_cti;
    logic [1:0]        bus_bte;
    logic [31:0]       bus_rdat;
    logic              bus_ack;

    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 0;

    always #4 clk = ~clk;

    sized_bus_adapter #(.ADDR_W(ADDR_W)) dut_i (.*);

    typedef struct packed {
        logic        we;
        logic [1:0]  size;
        logic [1:0]  off;
        logic [31:0] wdata;
        logic [31:0] rbus;
        logic [3:0]  esel;
        logic [31:0] ewdat;
        logic [31:0] erdata;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VT [NV] = '{
        '{1'b1, 2'b00, 2'd0, 32'hA1B2C3D4, 32'h0, 4'b1000, 32'hD4000000, 32'h0},
        '{1'b1, 2'b00, 2'd1, 32'hA1B2C3D4, 32'h0, 4'b0100, 32'h00D40000, 32'h0},
        '{1'b1, 2'b00, 2'd2, 32'hA1B2C3D4, 32'h0, 4'b0010, 32'h0000D400, 32'h0},
        '{1'b1, 2'b00, 2'd3, 32'hA1B2C3D4, 32'h0, 4'b0001, 32'h000000D4, 32'h0},
        '{1'b1, 2'b01, 2'd0, 32'hA1B2C3D4, 32'h0, 4'b1100, 32'hC3D40000, 32'h0},
        '{1'b1, 2'b01, 2'd1, 32'hA1B2C3D4, 32'h0, 4'b1100, 32'hC3D40000, 32'h0},
        '{1'b1, 2'b01, 2'd2, 32'hA1B2C3D4, 32'h0, 4'b0011, 32'h0000C3D4, 32'h0},
        '{1'b1, 2'b01, 2'd3, 32'hA1B2C3D4, 32'h0, 4'b0011, 32'h0000C3D4, 32'h0},
        '{1'b1, 2'b10, 2'd0, 32'hA1B2C3D4, 32'h0, 4'b1111, 32'hA1B2C3D4, 32'h0},
        '{1'b1, 2'b11, 2'd1, 32'hA1B2C3D4, 32'h0, 4'b0000, 32'h00000000, 32'h0},
        '{1'b0, 2'b00, 2'd0, 32'h0, 32'h11223344, 4'b1000, 32'h0, 32'h00000011},
        '{1'b0, 2'b00, 2'd2, 32'h0, 32'h11223344, 4'b0010, 32'h0, 32'h00000033},
        '{1'b0, 2'b01, 2'd1, 32'h0, 32'h11223344, 4'b1100, 32'h0, 32'h00001122},
        '{1'b0, 2'b01, 2'd3, 32'h0, 32'h11223344, 4'b0011, 32'h0, 32'h00003344},
        '{1'b0, 2'b10, 2'd2, 32'h0, 32'h11223344, 4'b1111, 32'h0, 32'h11223344},
        '{1'b0, 2'b11, 2'd0, 32'h0, 32'h11223344, 4'b0000, 32'h0, 32'h00000000}
    };

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic string size_tag(input logic [1:0] sz);
        case (sz)
            2'b00:   return "R1";
            2'b01:   return "R2";
            default: return "R3";
        endcase
    endfunction

    task automatic issue(input logic we, input logic [1:0] sz, input logic [ADDR_W-1:0] a, input logic [31:0] wd);
        core_req   = 1'b1;
        core_we    = we;
        core_size  = sz;
        core_addr  = a;
        core_wdata = wd;
    endtask

    // Start at a negedge with core idle; ends at the negedge where done is high
    task automatic run_vec(input vec_t v, input int dly, input logic [ADDR_W-1:0] base);
        logic [ADDR_W-1:0] a;
        a = base | ADDR_W'(v.off);
        issue(v.we, v.size, a, v.wdata);
        bus_rdat = v.rbus;
        @(negedge clk);
        core_req = 1'b0;
        chk(bus_cyc && bus_stb && core_busy, "R7 launch", {bus_cyc, bus_stb, core_busy}, 3'b111);
        chk(bus_sel == v.esel, size_tag(v.size), bus_sel, v.esel);
        chk(bus_wdat == v.ewdat, "R4 lanes", bus_wdat, v.ewdat);
        chk(bus_we == v.we, "R7 we", bus_we, v.we);
        chk(bus_adr == a[ADDR_W-1:2], "R11 adr", bus_adr, a[ADDR_W-1:2]);
        chk(bus_cti == 3'b000 && bus_bte == 2'b00, "R6 tags", {bus_cti, bus_bte}, 0);
        for (int d = 0; d < dly; d++) begin
            @(negedge clk);
            chk(bus_cyc && bus_sel == v.esel && bus_wdat == v.ewdat && core_busy && !core_done,
                "R7 hold", {bus_cyc, bus_sel, bus_wdat}, {1'b1, v.esel, v.ewdat});
        end
        bus_ack = 1'b1;
        @(negedge clk);
        bus_ack = 1'b0;
        chk(!bus_cyc && !bus_stb && !core_busy && core_done, "R8 release",
            {bus_cyc, bus_stb, core_busy, core_done}, 4'b0001);
        chk(core_rdata == v.erdata, "R5 rdata", core_rdata, v.erdata);
    endtask

    initial begin
        #(8 * 150000);
        if (!ended) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; core_req = 0; core_we = 0; core_size = 0; core_addr = 0;
        core_wdata = 0; bus_rdat = 0; bus_ack = 0;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(!bus_cyc && !bus_stb && !core_busy && !core_done && bus_sel == 0, "R10 reset",
            {bus_cyc, core_busy, core_done, bus_sel}, 0);
        rst = 1'b0;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            run_vec(VT[i], i % 3, 32'h4000_1000 + 32'(i) * 32'h10);
            @(negedge clk);
            chk(!core_done, "R8 pulse", core_done, 0);
        end

        // R9: request while busy is ignored and not queued
        run_vec_busy();

        // Back-to-back: done of first and acceptance of next in one cycle
        issue(1'b0, 2'b00, 32'h0000_2003, 32'h0);
        bus_rdat = 32'hCAFEF00D;
        @(negedge clk);
        core_req = 1'b0;
        bus_ack = 1'b1;
        @(negedge clk);
        bus_ack = 1'b0;
        chk(core_done && core_rdata == 32'h0000000D, "R8 b2b done", core_rdata, 32'h0000000D);
        issue(1'b1, 2'b01, 32'h0000_3002, 32'h0000BEEF);
        @(negedge clk);
        core_req = 1'b0;
        chk(bus_cyc && bus_sel == 4'b0011 && bus_wdat == 32'h0000BEEF && !core_done,
            "R7 b2b launch", {bus_sel, bus_wdat}, {4'b0011, 32'h0000BEEF});
        chk(bus_adr == 30'h0000_0C00, "R11 b2b adr", bus_adr, 30'h0000_0C00);
        bus_ack = 1'b1;
        @(negedge clk);
        bus_ack = 1'b0;
        chk(core_done && !bus_cyc, "R8 b2b second", {core_done, bus_cyc}, 2'b10);
        @(negedge clk);

        // R10: reset aborts a running cycle
        issue(1'b1, 2'b10, 32'h0000_5000, 32'h12345678);
        @(negedge clk);
        core_req = 1'b0;
        chk(bus_cyc, "R10 pre-abort", bus_cyc, 1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(!bus_cyc && !core_busy && bus_sel == 0 && !core_done, "R10 abort",
            {bus_cyc, core_busy, bus_sel}, 0);
        @(negedge clk);
        chk(!bus_cyc, "R10 stays idle", bus_cyc, 0);

        ended = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    task automatic run_vec_busy();
        issue(1'b1, 2'b00, 32'h0000_6001, 32'h000000AB);
        @(negedge clk);
        chk(bus_sel == 4'b0100 && bus_wdat == 32'h00AB0000, "R9 first", {bus_sel, bus_wdat},
            {4'b0100, 32'h00AB0000});
        issue(1'b1, 2'b10, 32'h0000_7000, 32'hFFFFFFFF);
        repeat (2) begin
            @(negedge clk);
            chk(core_busy && bus_sel == 4'b0100 && bus_adr == 30'h0000_1800,
                "R9 ignore", {bus_sel, bus_adr}, {4'b0100, 30'h0000_1800});
        end
        core_req = 1'b0;
        bus_ack = 1'b1;
        @(negedge clk);
        bus_ack = 1'b0;
        chk(core_done && !bus_cyc, "R9 done", {core_done, bus_cyc}, 2'b10);
        repeat (2) begin
            @(negedge clk);
            chk(!bus_cyc && !core_busy, "R9 not queued", {bus_cyc, core_busy}, 0);
        end
    endtask

endmodule